// File: doc/BRIEF.md
# Timebase and Decrementer Unit

This block holds three counters that move on a shared tick strobe. The primary timebase and the alternate timebase are 64-bit up-counters. The decrementer is a 32-bit down-counter. A single-cycle register port lets software read or write each 32-bit half of either timebase, or the decrementer. Software can rewrite one half of a running timebase and the other half keeps its value.

The decrementer raises a sticky exception request whenever its sign goes from non-negative to negative. This happens when it counts past zero into 0xFFFFFFFF, or when software writes a negative value over a non-negative one. The request stays high until software acknowledges it.

A small control state machine has three states. In INIT it holds all counters for the first cycle after reset. In RUN the timebases count. In FROZEN the timebases hold their values while the decrementer keeps counting. The transitions are:

- INIT→RUN or INIT→FROZEN on the first clock, chosen by the enable input.
- RUN→FROZEN when the enable input is low.
- FROZEN→RUN when the enable input is high.

Two side modes change how values are read. Clamp mode makes a negative decrementer read as zero. Clock-register mode masks the low word of the primary timebase to bits 29..7.

Top module: `tbdec_unit`

## Requirements
- R1: After reset, all timebase halves read 0, the decrementer reads 0xFFFFFFFF and `dec_irq` is low. This initial all-ones load raises no exception.
- R2: In RUN state, each cycle with `tick` high adds one to the primary timebase, and a carry propagates from the low half into the high half.
- R3: Register addresses are 0 = primary low half and 1 = primary high half. A write to one half keeps the other half. A write takes priority over a tick in the same cycle, so the written timebase does not also increment.
- R4: The alternate timebase sits at address 2 (low half) and address 3 (high half), with the same write rules as the primary. It holds its own value and advances on the same ticks.
- R5: `tb_en` is sampled into the state machine, so a change takes effect one clock later. While frozen, both timebases hold their values and the decrementer keeps counting. Both timebases resume from the held values.
- R6: The decrementer is at address 4. It loses one per tick, and a write in the same cycle takes priority over the tick.
- R7: When the decrementer counts down from 0, it becomes 0xFFFFFFFF and sets `dec_irq`.
- R8: A write with bit 31 set over a value with bit 31 clear sets `dec_irq`. A write over a value that already has bit 31 set does not set it.
- R9: `dec_irq` stays high until `irq_ack` is pulsed. If a new exception event and an acknowledge occur in the same cycle, the flag stays set.
- R10: With `clamp_mode` high, a decrementer value with bit 31 set reads as 0. With `clamp_mode` low, the raw value is returned.
- R11: With `rtc_mode` high, writes to and reads from the primary low half are masked with 0x3FFFFF80. The alternate timebase is not affected.
- R12: Addresses 5 to 7 read 0, and a write to them changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe for all counters |
| tb_en | input | 1 | High lets the timebases run, low freezes them |
| clamp_mode | input | 1 | When high, a negative decrementer reads as zero |
| rtc_mode | input | 1 | When high, masks the primary low half |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_ack | input | 1 | Clears the exception request |
| dec_irq | output | 1 | Sticky decrementer exception request |

## Verification
The bench uses the default parameters: a 32-bit register half, a 64-bit timebase and a 32-bit decrementer. With these sizes, a carry across the 0xFFFFFFFF low-half boundary and the decrementer's underflow through zero are each reached with a single tick from preloaded values, so no long runs are needed. The full 32-bit width also exercises the fixed 0x3FFFFF80 low-word mask exactly as specified, and allows sign-transition writes at 0x80000000 and above.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_TB_LO  = 3'd0,
        SEL_TB_HI  = 3'd1,
        SEL_ALT_LO = 3'd2,
        SEL_ALT_HI = 3'd3,
        SEL_DEC    = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } tb_state_e;
endpackage

// File: rtl/tbdec_tb_counter.sv
module tbdec_tb_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] value
);
    localparam int FULL_W = 2 * HALF_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_lo) begin
            value <= {value[FULL_W-1:HALF_W], wdata};
        end else if (wr_hi) begin
            value <= {wdata, value[HALF_W-1:0]};
        end else if (cnt_en) begin
            value <= value + FULL_W'(1);
        end
    end
endmodule

// File: rtl/tbdec_decrementer.sv
module tbdec_decrementer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         trip
);
    logic [W-1:0] next_val;

    always_comb begin
        if (wr) begin
            next_val = wdata;
        end else if (cnt_en) begin
            next_val = value - W'(1);
        end else begin
            next_val = value;
        end
    end

    // sign goes from clear to set on this update
    assign trip = next_val[W-1] & ~value[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '1;
        end else begin
            value <= next_val;
        end
    end
endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
    import tbdec_pkg::*;
#(
    parameter int          REG_W    = 32,
    parameter int          DEC_W    = 32,
    parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tb_en,
    input  logic             clamp_mode,
    input  logic             rtc_mode,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_ack,
    output logic             dec_irq
);
    localparam int TB_W   = 2 * REG_W;
    localparam int N_TB   = 2;
    localparam logic [REG_W-1:0] LO_MASK = REG_W'(RTC_MASK);

    tb_state_e state_q, state_d;
    logic      tb_cnt_en, dec_cnt_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   state_d = tb_en ? ST_RUN : ST_FROZEN;
            ST_RUN:    if (!tb_en) state_d = ST_FROZEN;
            ST_FROZEN: if (tb_en)  state_d = ST_RUN;
            default:   state_d = ST_INIT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        tb_cnt_en  = 1'b0;
        dec_cnt_en = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                tb_cnt_en  = 1'b0;
                dec_cnt_en = 1'b0;
            end
            ST_RUN: begin
                tb_cnt_en  = tick;
                dec_cnt_en = tick;
            end
            ST_FROZEN: begin
                tb_cnt_en  = 1'b0;
                dec_cnt_en = tick;
            end
            default: begin
                tb_cnt_en  = 1'b0;
                dec_cnt_en = 1'b0;
            end
        endcase
    end

    logic [TB_W-1:0] tb_val [N_TB];
    logic [TB_W-1:0] tb_prim, tb_alt;

    for (genvar g = 0; g < N_TB; g++) begin : g_tb
        localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(2 * g);
        localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(2 * g + 1);
        logic [REG_W-1:0] wdata_g;
        if (g == 0) begin : g_rtc
            assign wdata_g = rtc_mode ? (wr_data & LO_MASK) : wr_data;
        end else begin : g_plain
            assign wdata_g = wr_data;
        end
        logic wr_lo_g, wr_hi_g;
        assign wr_lo_g = wr_en && (addr == LO_SEL);
        // the high half is never masked
        assign wr_hi_g = wr_en && (addr == HI_SEL);
        tbdec_tb_counter #(.HALF_W(REG_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_en (tb_cnt_en),
            .wr_lo  (wr_lo_g),
            .wr_hi  (wr_hi_g && !wr_lo_g),
            .wdata  (wr_hi_g ? wr_data : wdata_g),
            .value  (tb_val[g])
        );
    end

    assign tb_prim = tb_val[0];
    assign tb_alt  = tb_val[1];

    logic [DEC_W-1:0] dec_val;
    logic             dec_trip;

    tbdec_decrementer #(.W(DEC_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (dec_cnt_en),
        .wr     (wr_en && (addr == SEL_DEC)),
        .wdata  (DEC_W'(wr_data)),
        .value  (dec_val),
        .trip   (dec_trip)
    );

    // sticky request, a new event wins over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_irq <= 1'b0;
        end else if (dec_trip) begin
            dec_irq <= 1'b1;
        end else if (irq_ack) begin
            dec_irq <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            SEL_TB_LO:  rd_data = rtc_mode ? (tb_prim[REG_W-1:0] & LO_MASK)
                                           : tb_prim[REG_W-1:0];
            SEL_TB_HI:  rd_data = tb_prim[TB_W-1:REG_W];
            SEL_ALT_LO: rd_data = tb_alt[REG_W-1:0];
            SEL_ALT_HI: rd_data = tb_alt[TB_W-1:REG_W];
            SEL_DEC:    rd_data = (clamp_mode && dec_val[DEC_W-1]) ? '0
                                                                    : REG_W'(dec_val);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tbdec_checker.sv
module tbdec_checker
    import tbdec_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int DEC_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               tb_en,
    input logic               clamp_mode,
    input logic               wr_en,
    input logic [SEL_W-1:0]   addr,
    input logic [REG_W-1:0]   rd_data,
    input logic               irq_ack,
    input logic               dec_irq,
    input logic [2*REG_W-1:0] tb_prim,
    input logic [DEC_W-1:0]   dec_val,
    input logic               dec_trip
);
    localparam int TB_W = 2 * REG_W;

    assert_lo_write_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_TB_LO) |=> tb_prim[TB_W-1:REG_W] == $past(tb_prim[TB_W-1:REG_W]));

    assert_frozen_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tb_en) && !(wr_en && (addr == SEL_TB_LO || addr == SEL_TB_HI)))
        |=> $stable(tb_prim));

    assert_dec_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr_en && addr == SEL_DEC)) |=> $stable(dec_val));

    assert_neg_over_neg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_irq && wr_en && addr == SEL_DEC && dec_val[DEC_W-1]) |=> !dec_irq);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_irq && !irq_ack) |=> dec_irq);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_irq && irq_ack && !dec_trip) |=> !dec_irq);

    assert_clamp_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_mode && addr == SEL_DEC && dec_val[DEC_W-1]) |-> rd_data == '0);
endmodule

bind tbdec_unit tbdec_checker #(.REG_W(REG_W), .DEC_W(DEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .tb_en      (tb_en),
    .clamp_mode (clamp_mode),
    .wr_en      (wr_en),
    .addr       (addr),
    .rd_data    (rd_data),
    .irq_ack    (irq_ack),
    .dec_irq    (dec_irq),
    .tb_prim    (tb_prim),
    .dec_val    (dec_val),
    .dec_trip   (dec_trip)
);

// File: tb/tbdec_unit_test.sv
module tbdec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        tb_en = 1'b1;
    logic        clamp_mode = 1'b0;
    logic        rtc_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_ack = 1'b0;
    logic        dec_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tbdec_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tb_en(tb_en),
        .clamp_mode(clamp_mode), .rtc_mode(rtc_mode), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_ack(irq_ack), .dec_irq(dec_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d);
            check("R1 timebase half after reset", d, 32'h0);
        end
        rd(3'd4, d);
        check("R1 decrementer after reset", d, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R1 no exception from initial load", {31'b0, dec_irq}, 32'h0);
    endtask

    task automatic t_count_carry;
        logic [31:0] d;
        wr(3'd1, 32'h0000_0001);
        wr(3'd0, 32'hFFFF_FFFF);
        ticks(1);
        rd(3'd0, d); check("R2 low half after carry", d, 32'h0);
        rd(3'd1, d); check("R2 high half after carry", d, 32'h2);
        ticks(3);
        rd(3'd0, d); check("R2 three ticks", d, 32'h3);
    endtask

    task automatic t_half_writes;
        logic [31:0] d;
        wr(3'd1, 32'hAAAA_0000);
        rd(3'd0, d); check("R3 high write keeps low", d, 32'h3);
        wr(3'd0, 32'h0000_5555);
        rd(3'd1, d); check("R3 low write keeps high", d, 32'hAAAA_0000);
        wr(3'd2, 32'h0000_0100);
        wr(3'd3, 32'h0000_0007);
        // write and tick together on primary low
        wr_en = 1'b1; addr = 3'd0; wr_data = 32'd10; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(3'd0, d); check("R3 write beats tick", d, 32'd10);
        rd(3'd2, d); check("R4 alternate ticks alongside", d, 32'h101);
        rd(3'd3, d); check("R4 alternate high held", d, 32'h7);
        ticks(2);
        rd(3'd2, d); check("R4 alternate shares ticks", d, 32'h103);
        rd(3'd0, d); check("R4 primary independent", d, 32'd12);
    endtask

    task automatic t_freeze;
        logic [31:0] d;
        wr(3'd4, 32'd100);
        tb_en = 1'b0;
        @(negedge clk);
        ticks(5);
        rd(3'd0, d); check("R5 primary frozen", d, 32'd12);
        rd(3'd2, d); check("R5 alternate frozen", d, 32'h103);
        rd(3'd4, d); check("R5 decrementer runs while frozen", d, 32'd95);
        tb_en = 1'b1;
        @(negedge clk);
        ticks(2);
        rd(3'd0, d); check("R5 primary resumes", d, 32'd14);
        rd(3'd2, d); check("R5 alternate resumes", d, 32'h105);
    endtask

    task automatic t_dec_underflow;
        logic [31:0] d;
        wr(3'd4, 32'd2);
        wr_en = 1'b1; addr = 3'd4; wr_data = 32'd7; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(3'd4, d); check("R6 write beats tick", d, 32'd7);
        wr(3'd4, 32'd2);
        ticks(2);
        rd(3'd4, d); check("R6 counts down", d, 32'd0);
        check("R7 no exception at zero", {31'b0, dec_irq}, 32'h0);
        ticks(1);
        rd(3'd4, d); check("R7 wraps to all ones", d, 32'hFFFF_FFFF);
        check("R7 exception on underflow", {31'b0, dec_irq}, 32'h1);
        clamp_mode = 1'b1;
        rd(3'd4, d); check("R10 clamp reads zero", d, 32'h0);
        clamp_mode = 1'b0;
        rd(3'd4, d); check("R10 normal reads negative", d, 32'hFFFF_FFFF);
        ticks(3);
        check("R9 sticky without ack", {31'b0, dec_irq}, 32'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R9 cleared by ack", {31'b0, dec_irq}, 32'h0);
    endtask

    task automatic t_dec_writes;
        logic [31:0] d;
        wr(3'd4, 32'h8000_0000);
        check("R8 negative over negative quiet", {31'b0, dec_irq}, 32'h0);
        wr(3'd4, 32'd5);
        check("R8 positive write quiet", {31'b0, dec_irq}, 32'h0);
        wr(3'd4, 32'h9000_0000);
        check("R8 negative over positive fires", {31'b0, dec_irq}, 32'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        wr(3'd4, 32'd0);
        tick = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        tick = 1'b0; irq_ack = 1'b0;
        check("R9 event wins over ack", {31'b0, dec_irq}, 32'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        rd(3'd4, d); check("R6 count after wrap", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_rtc;
        logic [31:0] d;
        wr(3'd0, 32'h1234_5678);
        rtc_mode = 1'b1;
        rd(3'd0, d); check("R11 masked read", d, 32'h1234_5600);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); check("R11 alternate unmasked", d, 32'hFFFF_FFFF);
        rtc_mode = 1'b0;
        rd(3'd0, d); check("R11 masked write stored", d, 32'h3FFF_FF80);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(3'd0, 32'h1111_1111);
        wr(3'd4, 32'h2222_2222);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hDEAD_BEEF);
            rd(3'(a), d); check("R12 unmapped reads zero", d, 32'h0);
        end
        rd(3'd0, d); check("R12 timebase untouched", d, 32'h1111_1111);
        rd(3'd4, d); check("R12 decrementer untouched", d, 32'h2222_2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        @(negedge clk);
        t_count_carry;
        t_half_writes;
        t_freeze;
        t_dec_underflow;
        t_dec_writes;
        t_rtc;
        t_unmapped;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule